// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block judges bus accesses against a table of protection regions. Each region holds an inclusive address window with 32-byte granularity, a valid bit, an optional process-ID requirement and a nibble of rights for every bus master. Several access ports are checked in the same cycle. Each port receives a combinational allow or deny answer, which the surrounding fabric uses to pass or fault the access.

Regions may overlap. An access is allowed when at least one valid region covering its address grants the requested right to its master. An access that no such region grants is denied. Processor masters carry two extra rights: execute, and permission to run in user mode. The first denied access is kept in a capture register together with an error flag. The capture stays frozen until software clears the flag.

Descriptors are written one field at a time through a simple write strobe that names a region index and a field selector.

Top module: `region_guard`

## Requirements
- R1: After reset every region is invalid, so every valid access is denied, and the error flag is 0.
- R2: A region covers block addresses `addr[31:5]` from its start block to its end block, both inclusive. Byte 31 of the end block is inside the region, and the byte just below the start block is outside it. Field 0 writes the start and field 1 writes the end, each taken from `cfgWrData[31:5]`.
- R3: Field 2 holds one nibble per master, with master m at bits [4m+3:4m]. Within a nibble, bit 0 is read, bit 1 is write, bit 2 is execute and bit 3 is user-allowed. Access type 0 is read, 1 is write and 2 is execute.
- R4: When regions overlap, an access is allowed if any valid covering region grants the requested right.
- R5: Field 3 holds the region's valid flag in bit 0, a PID-required flag in bit 1 and the PID in bits [15:8]. A region that requires a PID applies only when `portPid` equals its PID.
- R6: Masters with an ID below `NUM_CPU` are processors. A processor in user mode (`portUser`=1) is granted only by regions whose user bit is set for it. In supervisor mode the user bit has no effect.
- R7: For masters that are not processors, execute is always denied, and the user bit and `portUser` have no effect.
- R8: All ports are judged independently in the same cycle.
- R9: When the flag is clear and one or more ports are denied, the next clock edge sets the flag and captures the address, master, type and port of the lowest-numbered denied port.
- R10: While the flag is set, the capture does not change. `errClear` drops the flag. If a denial arrives in the same cycle as `errClear`, that denial is captured instead.
- R11: A region whose valid bit is 0 grants nothing. A port with `portValid`=0 is never allowed and is never captured.
- R12: Access type 3 is always denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Descriptor field write strobe |
| cfgRegion | input | 4 | Region index to write |
| cfgField | input | 2 | Field selector: 0 start, 1 end, 2 rights, 3 control |
| cfgWrData | input | 32 | Field value |
| portValid | input | 4 | Access present, one bit per port |
| portMaster | input | 8 | Master ID, 2 bits per port |
| portAddr | input | 128 | Byte address, 32 bits per port |
| portType | input | 8 | Access type, 2 bits per port |
| portUser | input | 4 | User mode, one bit per port |
| portPid | input | 32 | Process ID, 8 bits per port |
| portAllow | output | 4 | Access allowed, one bit per port |
| errClear | input | 1 | Clears the error flag |
| errFlag | output | 1 | A denial has been captured |
| errAddr | output | 32 | Captured address |
| errMaster | output | 2 | Captured master ID |
| errType | output | 2 | Captured access type |
| errPort | output | 2 | Port that produced the capture |

## Verification
The bench builds the block with its default parameters: 16 regions, 4 ports, 4 masters of which 2 are processors, 32-bit addresses and 8-bit process IDs. With these values it can reach both processor and non-processor masters, all four access types and simultaneous denials on several ports. Random region tables are kept inside a small address window, so overlaps, window edges and PID matches and mismatches all occur often. These are mixed with directed checks of edge bytes, user-mode execution and capture priority.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_e;

  typedef enum logic [1:0] {
    FLD_START = 2'd0,
    FLD_END   = 2'd1,
    FLD_PERM  = 2'd2,
    FLD_CTRL  = 2'd3
  } cfgField_e;

  localparam int GRAN_BITS = 5;

  typedef struct packed {
    logic wrStart;
    logic wrEnd;
    logic wrPerm;
    logic wrCtrl;
    logic capLoad;
    logic capClear;
  } ctlStrobe_t;

endpackage

// File: rtl/region_guard_match.sv
module region_guard_match
  import region_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int NUM_CPU     = 2,
  parameter int BLK_W       = 27,
  parameter int PID_W       = 8,
  parameter int MID_W       = 2,
  parameter int PERM_W      = 16
) (
  input  logic [NUM_REGIONS-1:0][BLK_W-1:0]  regStart,
  input  logic [NUM_REGIONS-1:0][BLK_W-1:0]  regEnd,
  input  logic [NUM_REGIONS-1:0][PERM_W-1:0] regPerm,
  input  logic [NUM_REGIONS-1:0]             regValid,
  input  logic [NUM_REGIONS-1:0]             regPidEn,
  input  logic [NUM_REGIONS-1:0][PID_W-1:0]  regPid,
  input  logic                               accValid,
  input  logic [MID_W-1:0]                   accMaster,
  input  logic [BLK_W-1:0]                   accBlk,
  input  logic [1:0]                         accType,
  input  logic                               accUser,
  input  logic [PID_W-1:0]                   accPid,
  output logic                               accAllow,
  output logic                               accDeny
);

  logic isCpu;
  logic [NUM_REGIONS-1:0] grant;

  assign isCpu = int'(accMaster) < NUM_CPU;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : gReg
    logic [3:0] nib;
    logic hit;
    logic ok;
    assign nib = regPerm[r][4*accMaster +: 4];
    assign hit = regValid[r] && (accBlk >= regStart[r]) && (accBlk <= regEnd[r])
                 && (!regPidEn[r] || (regPid[r] == accPid));
    always_comb begin
      unique case (accType)
        ACC_READ:  ok = nib[0];
        ACC_WRITE: ok = nib[1];
        ACC_EXEC:  ok = isCpu && nib[2];
        default:   ok = 1'b0;
      endcase
      if (isCpu && accUser && !nib[3]) ok = 1'b0;
    end
    assign grant[r] = hit && ok;
  end

  assign accAllow = accValid && (|grant);
  assign accDeny  = accValid && !(|grant);

endmodule

// File: rtl/region_guard_ctrl.sv
module region_guard_ctrl
  import region_guard_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 2
) (
  input  logic                 cfgWrEn,
  input  logic [1:0]           cfgField,
  input  logic [NUM_PORTS-1:0] portDeny,
  input  logic                 errClear,
  input  logic                 errFlag,
  output ctlStrobe_t           stb,
  output logic [PORT_W-1:0]    capPort
);

  always_comb begin
    stb = '0;
    if (cfgWrEn) begin
      unique case (cfgField)
        FLD_START: stb.wrStart = 1'b1;
        FLD_END:   stb.wrEnd   = 1'b1;
        FLD_PERM:  stb.wrPerm  = 1'b1;
        default:   stb.wrCtrl  = 1'b1;
      endcase
    end
    stb.capClear = errClear;
    stb.capLoad  = (|portDeny) && (!errFlag || errClear);
  end

  // lowest-numbered denied port wins the capture
  always_comb begin
    capPort = '0;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (portDeny[p]) capPort = PORT_W'(p);
    end
  end

endmodule

// File: rtl/region_guard_dp.sv
module region_guard_dp
  import region_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int NUM_PORTS   = 4,
  parameter int NUM_CPU     = 2,
  parameter int ADDR_W      = 32,
  parameter int PID_W       = 8,
  parameter int MID_W       = 2,
  parameter int REG_W       = 4,
  parameter int PORT_W      = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctlStrobe_t                  stb,
  input  logic [REG_W-1:0]            cfgRegion,
  input  logic [ADDR_W-1:0]           cfgWrData,
  input  logic [PORT_W-1:0]           capPort,
  input  logic [NUM_PORTS-1:0]        portValid,
  input  logic [NUM_PORTS*MID_W-1:0]  portMaster,
  input  logic [NUM_PORTS*ADDR_W-1:0] portAddr,
  input  logic [NUM_PORTS*2-1:0]      portType,
  input  logic [NUM_PORTS-1:0]        portUser,
  input  logic [NUM_PORTS*PID_W-1:0]  portPid,
  output logic [NUM_PORTS-1:0]        portAllow,
  output logic [NUM_PORTS-1:0]        portDeny,
  output logic                        errFlag,
  output logic [ADDR_W-1:0]           errAddr,
  output logic [MID_W-1:0]            errMaster,
  output logic [1:0]                  errType,
  output logic [PORT_W-1:0]           errPort
);

  localparam int BLK_W  = ADDR_W - GRAN_BITS;
  localparam int PERM_W = 4 * (1 << MID_W);

  logic [NUM_REGIONS-1:0][BLK_W-1:0]  regStart;
  logic [NUM_REGIONS-1:0][BLK_W-1:0]  regEnd;
  logic [NUM_REGIONS-1:0][PERM_W-1:0] regPerm;
  logic [NUM_REGIONS-1:0]             regValid;
  logic [NUM_REGIONS-1:0]             regPidEn;
  logic [NUM_REGIONS-1:0][PID_W-1:0]  regPid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regStart <= '0;
      regEnd   <= '0;
      regPerm  <= '0;
      regValid <= '0;
      regPidEn <= '0;
      regPid   <= '0;
    end else begin
      if (stb.wrStart) regStart[cfgRegion] <= cfgWrData[ADDR_W-1:GRAN_BITS];
      if (stb.wrEnd)   regEnd[cfgRegion]   <= cfgWrData[ADDR_W-1:GRAN_BITS];
      if (stb.wrPerm)  regPerm[cfgRegion]  <= cfgWrData[PERM_W-1:0];
      if (stb.wrCtrl) begin
        regValid[cfgRegion] <= cfgWrData[0];
        regPidEn[cfgRegion] <= cfgWrData[1];
        regPid[cfgRegion]   <= cfgWrData[8 +: PID_W];
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gPort
    region_guard_match #(
      .NUM_REGIONS(NUM_REGIONS), .NUM_CPU(NUM_CPU), .BLK_W(BLK_W),
      .PID_W(PID_W), .MID_W(MID_W), .PERM_W(PERM_W)
    ) uMatch (
      .regStart (regStart),
      .regEnd   (regEnd),
      .regPerm  (regPerm),
      .regValid (regValid),
      .regPidEn (regPidEn),
      .regPid   (regPid),
      .accValid (portValid[p]),
      .accMaster(portMaster[p*MID_W +: MID_W]),
      .accBlk   (portAddr[p*ADDR_W + GRAN_BITS +: BLK_W]),
      .accType  (portType[2*p +: 2]),
      .accUser  (portUser[p]),
      .accPid   (portPid[p*PID_W +: PID_W]),
      .accAllow (portAllow[p]),
      .accDeny  (portDeny[p])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag   <= 1'b0;
      errAddr   <= '0;
      errMaster <= '0;
      errType   <= '0;
      errPort   <= '0;
    end else if (stb.capLoad) begin
      errFlag   <= 1'b1;
      errAddr   <= portAddr[capPort*ADDR_W +: ADDR_W];
      errMaster <= portMaster[capPort*MID_W +: MID_W];
      errType   <= portType[capPort*2 +: 2];
      errPort   <= capPort;
    end else if (stb.capClear) begin
      errFlag   <= 1'b0;
    end
  end

endmodule

// File: rtl/region_guard.sv
module region_guard
  import region_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int NUM_PORTS   = 4,
  parameter int NUM_MASTERS = 4,
  parameter int NUM_CPU     = 2,
  parameter int ADDR_W      = 32,
  parameter int PID_W       = 8,
  localparam int REG_W      = $clog2(NUM_REGIONS),
  localparam int MID_W      = $clog2(NUM_MASTERS),
  localparam int PORT_W     = $clog2(NUM_PORTS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWrEn,
  input  logic [REG_W-1:0]            cfgRegion,
  input  logic [1:0]                  cfgField,
  input  logic [ADDR_W-1:0]           cfgWrData,
  input  logic [NUM_PORTS-1:0]        portValid,
  input  logic [NUM_PORTS*MID_W-1:0]  portMaster,
  input  logic [NUM_PORTS*ADDR_W-1:0] portAddr,
  input  logic [NUM_PORTS*2-1:0]      portType,
  input  logic [NUM_PORTS-1:0]        portUser,
  input  logic [NUM_PORTS*PID_W-1:0]  portPid,
  output logic [NUM_PORTS-1:0]        portAllow,
  input  logic                        errClear,
  output logic                        errFlag,
  output logic [ADDR_W-1:0]           errAddr,
  output logic [MID_W-1:0]            errMaster,
  output logic [1:0]                  errType,
  output logic [PORT_W-1:0]           errPort
);

  ctlStrobe_t stb;
  logic [PORT_W-1:0]    capPort;
  logic [NUM_PORTS-1:0] portDeny;

  region_guard_ctrl #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) uCtrl (
    .cfgWrEn (cfgWrEn),
    .cfgField(cfgField),
    .portDeny(portDeny),
    .errClear(errClear),
    .errFlag (errFlag),
    .stb     (stb),
    .capPort (capPort)
  );

  region_guard_dp #(
    .NUM_REGIONS(NUM_REGIONS), .NUM_PORTS(NUM_PORTS), .NUM_CPU(NUM_CPU),
    .ADDR_W(ADDR_W), .PID_W(PID_W), .MID_W(MID_W), .REG_W(REG_W), .PORT_W(PORT_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cfgRegion (cfgRegion),
    .cfgWrData (cfgWrData),
    .capPort   (capPort),
    .portValid (portValid),
    .portMaster(portMaster),
    .portAddr  (portAddr),
    .portType  (portType),
    .portUser  (portUser),
    .portPid   (portPid),
    .portAllow (portAllow),
    .portDeny  (portDeny),
    .errFlag   (errFlag),
    .errAddr   (errAddr),
    .errMaster (errMaster),
    .errType   (errType),
    .errPort   (errPort)
  );

endmodule

// File: rtl/region_guard_sva.sv
module region_guard_sva #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 32,
  parameter int PORT_W    = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_PORTS-1:0]   portValid,
  input logic [NUM_PORTS*2-1:0] portType,
  input logic [NUM_PORTS-1:0]   portAllow,
  input logic                   errClear,
  input logic                   errFlag,
  input logic [ADDR_W-1:0]      errAddr,
  input logic [PORT_W-1:0]      errPort
);

  logic [NUM_PORTS-1:0] denied;
  assign denied = portValid & ~portAllow;

  // R11: idle ports are never allowed
  a_r11_idle_no_allow: assert property (@(posedge clk) disable iff (!rstN)
    (portAllow & ~portValid) == '0);

  // R9: first denial sets the flag
  a_r9_capture_sets: assert property (@(posedge clk) disable iff (!rstN)
    (!errFlag && (denied != '0)) |=> errFlag);

  // R9: flag only rises after a denial
  a_r9_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(denied != '0));

  // R10: capture frozen while flag set and not cleared
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClear) |=> (errFlag && $stable(errAddr) && $stable(errPort)));

  // R10: clear without denial drops the flag
  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    (errClear && (denied == '0)) |=> !errFlag);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gRsvd
    // R12: reserved type never allowed
    a_r12_rsvd_denied: assert property (@(posedge clk) disable iff (!rstN)
      (portValid[p] && (portType[2*p +: 2] == 2'd3)) |-> !portAllow[p]);
  end

endmodule

bind region_guard region_guard_sva #(
  .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .PORT_W(PORT_W)
) uSva (.*);

// File: tb/region_guard_test.sv
`timescale 1ns/1ps
module region_guard_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cfgWrEn = 1'b0;
  logic [3:0]   cfgRegion = '0;
  logic [1:0]   cfgField = '0;
  logic [31:0]  cfgWrData = '0;
  logic [3:0]   portValid = '0;
  logic [7:0]   portMaster = '0;
  logic [127:0] portAddr = '0;
  logic [7:0]   portType = '0;
  logic [3:0]   portUser = '0;
  logic [31:0]  portPid = '0;
  logic [3:0]   portAllow;
  logic         errClear = 1'b0;
  logic         errFlag;
  logic [31:0]  errAddr;
  logic [1:0]   errMaster;
  logic [1:0]   errType;
  logic [1:0]   errPort;

  always #10 clk = ~clk;

  region_guard uut (.*);

  int compared = 0;
  int mismatched = 0;

  logic [26:0] mStart [16];
  logic [26:0] mEnd   [16];
  logic [15:0] mPerm  [16];
  logic        mValid [16];
  logic        mPidEn [16];
  logic [7:0]  mPid   [16];

  logic        bV [4];
  logic [1:0]  bM [4];
  logic [31:0] bA [4];
  logic [1:0]  bT [4];
  logic        bU [4];
  logic [7:0]  bP [4];
  logic        bClr;

  logic        eFlag;
  logic [31:0] eAddr;
  logic [1:0]  eMaster, eType, ePort;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit expAllow(int p);
    bit any;
    any = 0;
    if (!bV[p]) return 0;
    for (int r = 0; r < 16; r++) begin
      logic [3:0] nb;
      bit cpu;
      bit ok;
      nb  = mPerm[r][4*bM[p] +: 4];
      cpu = (bM[p] < 2);
      ok  = 0;
      if (mValid[r] && bA[p][31:5] >= mStart[r] && bA[p][31:5] <= mEnd[r]
          && (!mPidEn[r] || mPid[r] == bP[p])) begin
        case (bT[p])
          2'd0: ok = nb[0];
          2'd1: ok = nb[1];
          2'd2: ok = cpu && nb[2];
          default: ok = 0;
        endcase
        if (cpu && bU[p] && !nb[3]) ok = 0;
      end
      if (ok) any = 1;
    end
    return any;
  endfunction

  task automatic cfgWrite(int r, int f, logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgRegion = 4'(r); cfgField = 2'(f); cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic setRegion(int r, logic [31:0] s, logic [31:0] e, logic [15:0] perm,
                           bit v, bit pe, logic [7:0] pid);
    cfgWrite(r, 0, s);
    cfgWrite(r, 1, e);
    cfgWrite(r, 2, {16'h0, perm});
    cfgWrite(r, 3, {16'h0, pid, 6'h0, pe, v});
    mStart[r] = s[31:5]; mEnd[r] = e[31:5]; mPerm[r] = perm;
    mValid[r] = v; mPidEn[r] = pe; mPid[r] = pid;
  endtask

  task automatic idleAll();
    for (int p = 0; p < 4; p++) begin
      bV[p] = 0; bM[p] = 0; bA[p] = 0; bT[p] = 0; bU[p] = 0; bP[p] = 0;
    end
    bClr = 0;
  endtask

  task automatic setPort(int p, int m, logic [31:0] a, int t, bit u, logic [7:0] pid);
    bV[p] = 1; bM[p] = 2'(m); bA[p] = a; bT[p] = 2'(t); bU[p] = u; bP[p] = pid;
  endtask

  // one access cycle: drive, check answers, then check capture after the edge
  task automatic step(string req, string capReq);
    bit found;
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      portValid[p] = bV[p];
      portMaster[2*p +: 2] = bM[p];
      portAddr[32*p +: 32] = bA[p];
      portType[2*p +: 2] = bT[p];
      portUser[p] = bU[p];
      portPid[8*p +: 8] = bP[p];
    end
    errClear = bClr;
    #1;
    found = 0;
    for (int p = 0; p < 4; p++) begin
      bit ea;
      ea = expAllow(p);
      chk(req, {31'h0, portAllow[p]}, {31'h0, ea});
      if (bV[p] && !ea && !found && (!eFlag || bClr)) begin
        found = 1;
        eFlag = 1; eAddr = bA[p]; eMaster = bM[p]; eType = bT[p]; ePort = 2'(p);
      end
    end
    if (!found && bClr) eFlag = 0;
    @(posedge clk);
    #1;
    chk(capReq, {31'h0, errFlag}, {31'h0, eFlag});
    if (eFlag) begin
      chk(capReq, errAddr, eAddr);
      chk(capReq, {30'h0, errMaster}, {30'h0, eMaster});
      chk(capReq, {30'h0, errType}, {30'h0, eType});
      chk(capReq, {30'h0, errPort}, {30'h0, ePort});
    end
  endtask

  task automatic clearFlag();
    idleAll(); bClr = 1;
    step("R10", "R10");
    idleAll();
  endtask

  initial begin
    #(200000 * 20);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    for (int r = 0; r < 16; r++) begin
      mStart[r] = 0; mEnd[r] = 0; mPerm[r] = 0; mValid[r] = 0; mPidEn[r] = 0; mPid[r] = 0;
    end
    eFlag = 0; eAddr = 0; eMaster = 0; eType = 0; ePort = 0;
    idleAll();
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {31'h0, errFlag}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: nothing granted after reset, denial captured on port 0
    setPort(0, 0, 32'h0000_1000, 0, 0, 8'h00);
    step("R1", "R9");
    clearFlag();

    // R2/R8: edges of region 0 across four ports; master0 read-only, master2 read/write
    setRegion(0, 32'h1000, 32'h10E0, 16'h0301, 1, 0, 8'h00);
    setPort(0, 0, 32'h0000_1000, 0, 0, 0);
    setPort(1, 0, 32'h0000_10FF, 0, 0, 0);
    setPort(2, 0, 32'h0000_0FFF, 0, 0, 0);
    setPort(3, 0, 32'h0000_1100, 0, 0, 0);
    step("R2", "R9");
    clearFlag();

    // R3: rights per master and type
    setPort(0, 0, 32'h1040, 1, 0, 0);
    setPort(1, 2, 32'h1040, 1, 0, 0);
    setPort(2, 1, 32'h1040, 0, 0, 0);
    setPort(3, 2, 32'h1040, 0, 0, 0);
    step("R3", "R9");
    clearFlag();

    // R4: overlap with region 1 granting master0 write only
    setRegion(1, 32'h1080, 32'h11E0, 16'h0002, 1, 0, 8'h00);
    setPort(0, 0, 32'h1090, 1, 0, 0);
    setPort(1, 0, 32'h1090, 0, 0, 0);
    setPort(2, 0, 32'h1150, 0, 0, 0);
    setPort(3, 0, 32'h1150, 1, 0, 0);
    step("R4", "R9");
    clearFlag();

    // R5: PID-gated region for master1
    setRegion(2, 32'h2000, 32'h20E0, 16'h00F0, 1, 1, 8'h5A);
    setPort(0, 1, 32'h2010, 0, 0, 8'h5A);
    setPort(1, 1, 32'h2010, 0, 0, 8'h5B);
    setPort(2, 1, 32'h20FF, 2, 1, 8'h5A);
    step("R5", "R9");
    clearFlag();

    // R6/R7: master0 RWX without user bit, master3 RW only
    setRegion(3, 32'h3000, 32'h30E0, 16'h3007, 1, 0, 8'h00);
    setPort(0, 0, 32'h3000, 2, 0, 0);
    setPort(1, 0, 32'h3000, 2, 1, 0);
    setPort(2, 3, 32'h3000, 0, 1, 0);
    setPort(3, 3, 32'h3000, 2, 0, 0);
    step("R6", "R9");
    clearFlag();
    setRegion(5, 32'h3000, 32'h30E0, 16'hF000, 1, 0, 8'h00);
    setPort(0, 3, 32'h3020, 2, 1, 0);
    setPort(1, 3, 32'h3020, 1, 1, 0);
    step("R7", "R9");
    clearFlag();

    // R12: reserved type with full rights
    setRegion(6, 32'h5000, 32'h50E0, 16'hFFFF, 1, 0, 8'h00);
    setPort(0, 0, 32'h5000, 3, 0, 0);
    setPort(1, 2, 32'h5000, 3, 0, 0);
    setPort(2, 0, 32'h5000, 0, 0, 0);
    step("R12", "R9");
    clearFlag();

    // R11: invalid region grants nothing; idle port never captured
    setRegion(4, 32'h4000, 32'h40E0, 16'hFFFF, 0, 0, 8'h00);
    setPort(1, 0, 32'h4000, 0, 0, 0);
    step("R11", "R9");
    clearFlag();
    bA[2] = 32'h4000; bT[2] = 0;
    step("R11", "R11");

    // R9/R10: priority, hold, clear with simultaneous denial
    setPort(1, 1, 32'h7000, 1, 0, 0);
    setPort(3, 2, 32'h7100, 0, 0, 0);
    setPort(0, 0, 32'h1000, 0, 0, 0);
    step("R9", "R9");
    idleAll();
    setPort(0, 0, 32'h7777, 2, 0, 0);
    step("R10", "R10");
    idleAll();
    setPort(2, 3, 32'h6660, 1, 0, 0);
    bClr = 1;
    step("R10", "R10");
    clearFlag();
    step("R10", "R10");

    // random phase
    for (int i = 0; i < 600; i++) begin
      if (i % 25 == 0) begin
        logic [31:0] s, len;
        s   = ($urandom % 256) << 5;
        len = ($urandom % 64) << 5;
        setRegion($urandom % 16, s, s + len, 16'($urandom),
                  ($urandom % 4) != 0, ($urandom % 3) == 0, 8'h5A + 8'($urandom % 2));
      end
      for (int p = 0; p < 4; p++) begin
        bV[p] = ($urandom % 5) != 0;
        bM[p] = 2'($urandom);
        bA[p] = $urandom % 32'h2400;
        bT[p] = 2'($urandom);
        bU[p] = 1'($urandom);
        bP[p] = 8'h5A + 8'($urandom % 2);
      end
      bClr = ($urandom % 4) == 0;
      step("R3", "R9");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule